// File: doc/BRIEF.md
# Bonded Link Bring-up Handshake Controller

This block brings up one end of a four-lane bonded serial link whose far end is an identical controller. That far end leaves reset on its own schedule, at an unrelated time. It works on symbols: each lane carries two 8b10b symbols per clock, as 16 data bits and 2 control flags. The encoder, the decoder, the serializers and the lane deskew buffers all sit outside the block. The controller drives the transmit symbols of every lane. It watches the received symbols after they have been deskewed.

After reset the controller sends an alignment word for a fixed window of cycles and looks for evidence that the peer is alive. If it finds that evidence, it sends a confirmation word and waits for the peer's confirmation. If it does not, it pauses for one idle cycle and opens the window again. Once both sides are confirmed, it fires a single deskew marker across all lanes at the same instant. It then waits for the peer's marker, swaps acknowledge words with the peer, and raises channel-ready. Every step forward depends only on what has been received, never on how the peer is timed.

Top module: `bond_link_bringup`

## Requirements
- R1: While `rst` is high and in the cycle after it, `channel_ready_o` is low and every lane transmits the idle word: all data bits zero and all control flags clear.
- R2: After reset is released, every lane transmits the alignment word for exactly CHECK_CYCLES consecutive cycles. In lane i, bits [7:0] carry K28.5 (0xBC) with control flag bit 2i set, and bits [15:8] carry 0x4A with flag bit 2i+1 clear.
- R3: If no qualifying word arrives during the window, the controller transmits one idle cycle and then starts a fresh window of alignment words.
- R4: If, in any cycle of the window including its first and last, all lanes receive either the alignment word or the confirmation word, the controller transmits the confirmation word when the window ends. The confirmation word is 0xBC with the K flag in the low symbol and 0x5C as data in the high symbol.
- R5: The deskew marker is sent only from the confirmation state, and only after the peer's confirmation word has been received on all lanes.
- R6: The deskew marker places K28.3 (0x7C) in both symbols of every lane, with both control flags set, in the same single cycle. The next cycle is idle.
- R7: The acknowledge word goes out only after the peer's deskew marker has been received. It is 0xBC with the K flag in the low symbol and 0x6E as data in the high symbol, and it repeats until the peer's acknowledge word is received.
- R8: `channel_ready_o` rises only after the peer's acknowledge word has been received. It then stays high, with idle words on every lane, until reset or loss of alignment.
- R9: `rst` or `align_lost_i` drops `channel_ready_o` in the next cycle and restarts the sequence from the reset state.
- R10: A received word counts only when every lane carries it in the same cycle with exactly the stated control flags. A partial-lane match or a wrong flag is ignored.
- R11: Two controllers wired back to back, with different one-way latencies and different reset release times, both reach channel-ready.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| align_lost_i | input | 1 | Loss of alignment; restarts the handshake |
| rx_data_i | input | LANES*16 | Deskewed received symbols, lane i in bits [16i+15:16i] |
| rx_k_i | input | LANES*2 | Received control flags, lane i in bits [2i+1:2i] |
| tx_data_o | output | LANES*16 | Transmitted symbols, same lane layout |
| tx_k_o | output | LANES*2 | Transmitted control flags |
| channel_ready_o | output | 1 | Link is up |

## Verification
The alignment window is first run with a single controller whose received stream is forced. The forced patterns are: constant idle, constant alignment or confirmation words, a one-cycle alignment word on the first or the last window cycle, an alignment word on only three lanes, and alignment words with a missing or an extra control flag. These patterns separate a correct window length, a correct restart and a correct all-lane, exact-flag match from an off-by-one window or a loose match. Two controllers are then joined through delay lines, using several pairs of latencies and reset release offsets, some shorter and some longer than a window. This shows that progress does not depend on the peer's phase. Monitors check that each controller sends its deskew marker, its acknowledge word and its ready flag only after receiving the matching peer word. The final tests pulse loss of alignment and reset while the link is up.

// File: rtl/bond_link_pkg.sv
package bond_link_pkg;

    localparam int SYM_W  = 8;
    localparam int LANE_W = 2 * SYM_W;
    localparam int FLAG_W = 2;

    localparam logic [SYM_W-1:0] K28_5     = 8'hBC;
    localparam logic [SYM_W-1:0] K28_3     = 8'h7C;
    localparam logic [SYM_W-1:0] TAG_ALIGN = 8'h4A;
    localparam logic [SYM_W-1:0] TAG_OK    = 8'h5C;
    localparam logic [SYM_W-1:0] TAG_ACK   = 8'h6E;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_ALIGN,
        WK_OK,
        WK_DESKEW,
        WK_ACK
    } word_kind_e;

    // one lane per clock: sym0 is the earlier symbol, kf[0] belongs to it
    typedef struct packed {
        logic [SYM_W-1:0]  sym1;
        logic [SYM_W-1:0]  sym0;
        logic [FLAG_W-1:0] kf;
    } lane_word_t;

    typedef struct packed {
        logic align;
        logic ok;
        logic deskew;
        logic ack;
    } rx_hits_t;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_CHECK,
        ST_RESTART,
        ST_ALIGN_OK,
        ST_SEND_DSK,
        ST_WAIT_DSK,
        ST_SEND_ACK,
        ST_READY
    } link_state_e;

    function automatic lane_word_t make_word(word_kind_e kind);
        lane_word_t w;
        w = '0;
        case (kind)
            WK_ALIGN:  begin w.sym0 = K28_5; w.sym1 = TAG_ALIGN; w.kf = 2'b01; end
            WK_OK:     begin w.sym0 = K28_5; w.sym1 = TAG_OK;    w.kf = 2'b01; end
            WK_ACK:    begin w.sym0 = K28_5; w.sym1 = TAG_ACK;   w.kf = 2'b01; end
            WK_DESKEW: begin w.sym0 = K28_3; w.sym1 = K28_3;     w.kf = 2'b11; end
            default:   w = '0;
        endcase
        return w;
    endfunction

    function automatic word_kind_e classify(lane_word_t w);
        word_kind_e kind;
        kind = WK_NONE;
        if (w.kf == 2'b11 && w.sym0 == K28_3 && w.sym1 == K28_3) begin
            kind = WK_DESKEW;
        end else if (w.kf == 2'b01 && w.sym0 == K28_5) begin
            case (w.sym1)
                TAG_ALIGN: kind = WK_ALIGN;
                TAG_OK:    kind = WK_OK;
                TAG_ACK:   kind = WK_ACK;
                default:   kind = WK_NONE;
            endcase
        end
        return kind;
    endfunction

    function automatic word_kind_e state_word(link_state_e s);
        word_kind_e kind;
        case (s)
            ST_CHECK:    kind = WK_ALIGN;
            ST_ALIGN_OK: kind = WK_OK;
            ST_SEND_DSK: kind = WK_DESKEW;
            ST_SEND_ACK: kind = WK_ACK;
            default:     kind = WK_NONE;
        endcase
        return kind;
    endfunction

endpackage

// File: rtl/bond_link_rx_match.sv
module bond_link_rx_match
    import bond_link_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES*LANE_W-1:0] rx_data_i,
    input  logic [LANES*FLAG_W-1:0] rx_k_i,
    output rx_hits_t                hits_o
);

    logic [LANES-1:0] lane_align;
    logic [LANES-1:0] lane_ok;
    logic [LANES-1:0] lane_dsk;
    logic [LANES-1:0] lane_ack;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_word_t word;
        word_kind_e kind;

        assign word = '{sym1: rx_data_i[g*LANE_W+SYM_W +: SYM_W],
                        sym0: rx_data_i[g*LANE_W +: SYM_W],
                        kf:   rx_k_i[g*FLAG_W +: FLAG_W]};
        assign kind = classify(word);

        assign lane_align[g] = (kind == WK_ALIGN);
        assign lane_ok[g]    = (kind == WK_OK);
        assign lane_dsk[g]   = (kind == WK_DESKEW);
        assign lane_ack[g]   = (kind == WK_ACK);
    end

    // a word counts only when the whole bonded channel carries it at once
    assign hits_o.align  = &lane_align;
    assign hits_o.ok     = &lane_ok;
    assign hits_o.deskew = &lane_dsk;
    assign hits_o.ack    = &lane_ack;

endmodule

// File: rtl/bond_link_tx_gen.sv
module bond_link_tx_gen
    import bond_link_pkg::*;
#(
    parameter int LANES = 4
) (
    input  word_kind_e              kind_i,
    output logic [LANES*LANE_W-1:0] tx_data_o,
    output logic [LANES*FLAG_W-1:0] tx_k_o
);

    lane_word_t word;

    assign word = make_word(kind_i);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign tx_data_o[g*LANE_W +: LANE_W] = {word.sym1, word.sym0};
        assign tx_k_o[g*FLAG_W +: FLAG_W]    = word.kf;
    end

endmodule

// File: rtl/bond_link_align_timer.sv
module bond_link_align_timer #(
    parameter int CHECK_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic hit_i,
    output logic done_o,
    output logic seen_o
);

    localparam int CNT_W = (CHECK_CYCLES > 1) ? $clog2(CHECK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHECK_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             seen_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (hit_i) begin
                seen_q <= 1'b1;
            end
        end
    end

    assign done_o = run_i && (cnt_q == LAST);
    // a hit in the closing cycle of the window still counts
    assign seen_o = seen_q | hit_i;

endmodule

// File: rtl/bond_link_bringup.sv
module bond_link_bringup
    import bond_link_pkg::*;
#(
    parameter int LANES        = 4,
    parameter int CHECK_CYCLES = 1024
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    align_lost_i,
    input  logic [LANES*16-1:0]     rx_data_i,
    input  logic [LANES*2-1:0]      rx_k_i,
    output logic [LANES*16-1:0]     tx_data_o,
    output logic [LANES*2-1:0]      tx_k_o,
    output logic                    channel_ready_o
);

    link_state_e state_q;
    link_state_e state_d;
    rx_hits_t    hits;
    logic        win_done;
    logic        win_seen;
    logic        dsk_seen_q;
    logic        ack_seen_q;
    logic        restart;
    logic        dsk_window;
    logic        ack_window;
    word_kind_e  tx_kind;

    assign restart = rst | align_lost_i;

    bond_link_rx_match #(.LANES(LANES)) u_rx_match (
        .rx_data_i (rx_data_i),
        .rx_k_i    (rx_k_i),
        .hits_o    (hits)
    );

    bond_link_align_timer #(.CHECK_CYCLES(CHECK_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (restart),
        .run_i  (state_q == ST_CHECK),
        .hit_i  (hits.align | hits.ok),
        .done_o (win_done),
        .seen_o (win_seen)
    );

    // the peer's marker may arrive while this side is still one step behind
    assign dsk_window = (state_q == ST_ALIGN_OK) || (state_q == ST_SEND_DSK) ||
                        (state_q == ST_WAIT_DSK);
    assign ack_window = (state_q == ST_WAIT_DSK) || (state_q == ST_SEND_ACK);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RESET:    state_d = ST_CHECK;
            ST_CHECK:    if (win_done) state_d = win_seen ? ST_ALIGN_OK : ST_RESTART;
            ST_RESTART:  state_d = ST_CHECK;
            ST_ALIGN_OK: if (hits.ok) state_d = ST_SEND_DSK;
            ST_SEND_DSK: state_d = ST_WAIT_DSK;
            ST_WAIT_DSK: if (dsk_seen_q || hits.deskew) state_d = ST_SEND_ACK;
            ST_SEND_ACK: if (ack_seen_q || hits.ack) state_d = ST_READY;
            ST_READY:    state_d = ST_READY;
            default:     state_d = ST_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (restart) begin
            state_q    <= ST_RESET;
            dsk_seen_q <= 1'b0;
            ack_seen_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RESET) begin
                dsk_seen_q <= 1'b0;
                ack_seen_q <= 1'b0;
            end else begin
                if (dsk_window && hits.deskew) dsk_seen_q <= 1'b1;
                if (ack_window && hits.ack)    ack_seen_q <= 1'b1;
            end
        end
    end

    assign tx_kind = state_word(state_q);

    bond_link_tx_gen #(.LANES(LANES)) u_tx_gen (
        .kind_i    (tx_kind),
        .tx_data_o (tx_data_o),
        .tx_k_o    (tx_k_o)
    );

    assign channel_ready_o = (state_q == ST_READY);

endmodule

// File: rtl/bond_link_bringup_chk.sv
module bond_link_bringup_chk
    import bond_link_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                align_lost_i,
    input logic [LANES*16-1:0] tx_data_o,
    input logic [LANES*2-1:0]  tx_k_o,
    input logic                channel_ready_o
);

    word_kind_e kind;
    logic       lanes_same;
    logic       tx_quiet;

    assign kind = classify('{sym1: tx_data_o[15:8], sym0: tx_data_o[7:0], kf: tx_k_o[1:0]});
    assign lanes_same = (tx_data_o == {LANES{tx_data_o[15:0]}}) &&
                        (tx_k_o == {LANES{tx_k_o[1:0]}});
    assign tx_quiet = (tx_data_o == '0) && (tx_k_o == '0);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!channel_ready_o && tx_quiet));

    // R9
    loss_drop_chk: assert property (@(posedge clk) disable iff (rst)
        align_lost_i |=> !channel_ready_o);

    // R6
    deskew_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == WK_DESKEW) |-> lanes_same);

    // R6
    deskew_single_chk: assert property (@(posedge clk) disable iff (rst || align_lost_i)
        (kind == WK_DESKEW) |=> tx_quiet);

    // R5
    deskew_after_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == WK_DESKEW) |-> ($past(kind) == WK_OK));

    // R8
    ready_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(channel_ready_o) |-> ($past(kind) == WK_ACK));

    // R8
    ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        channel_ready_o |-> tx_quiet);

    // R3
    align_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(kind == WK_ALIGN) |-> (kind == WK_OK || tx_quiet));

    // R4
    ok_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(kind == WK_OK) |-> ($past(kind) == WK_ALIGN));

endmodule

bind bond_link_bringup bond_link_bringup_chk #(.LANES(LANES)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .align_lost_i    (align_lost_i),
    .tx_data_o       (tx_data_o),
    .tx_k_o          (tx_k_o),
    .channel_ready_o (channel_ready_o)
);

// File: tb/bond_link_bringup_tb.sv
module bond_link_bringup_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LANES  = 4;
    localparam int WIN    = 64;
    localparam int DW     = LANES * 16;
    localparam int KW     = LANES * 2;
    localparam int MAXLAT = 16;

    localparam int K_BAD = -1, K_IDLE = 0, K_ALIGN = 1, K_OK = 2, K_DSK = 3, K_ACK = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_a, rst_b, lost_a, lost_b;
    logic [DW-1:0] tx_a_d, tx_b_d, rx_a_d, rx_b_d, inj_d;
    logic [KW-1:0] tx_a_k, tx_b_k, rx_a_k, rx_b_k, inj_k;
    logic          rdy_a, rdy_b, inj_en;
    int            lat_ab, lat_ba;
    int            n_chk = 0, n_err = 0;

    logic [DW-1:0] dab_d [MAXLAT];
    logic [KW-1:0] dab_k [MAXLAT];
    logic [DW-1:0] dba_d [MAXLAT];
    logic [KW-1:0] dba_k [MAXLAT];

    always @(posedge clk) begin
        dab_d[0] <= tx_a_d; dab_k[0] <= tx_a_k;
        dba_d[0] <= tx_b_d; dba_k[0] <= tx_b_k;
        for (int i = 1; i < MAXLAT; i++) begin
            dab_d[i] <= dab_d[i-1]; dab_k[i] <= dab_k[i-1];
            dba_d[i] <= dba_d[i-1]; dba_k[i] <= dba_k[i-1];
        end
    end

    assign rx_b_d = dab_d[lat_ab-1];
    assign rx_b_k = dab_k[lat_ab-1];
    assign rx_a_d = inj_en ? inj_d : dba_d[lat_ba-1];
    assign rx_a_k = inj_en ? inj_k : dba_k[lat_ba-1];

    bond_link_bringup #(.LANES(LANES), .CHECK_CYCLES(WIN)) u_dut (
        .clk (clk), .rst (rst_a), .align_lost_i (lost_a),
        .rx_data_i (rx_a_d), .rx_k_i (rx_a_k),
        .tx_data_o (tx_a_d), .tx_k_o (tx_a_k), .channel_ready_o (rdy_a)
    );

    bond_link_bringup #(.LANES(LANES), .CHECK_CYCLES(WIN)) u_peer (
        .clk (clk), .rst (rst_b), .align_lost_i (lost_b),
        .rx_data_i (rx_b_d), .rx_k_i (rx_b_k),
        .tx_data_o (tx_b_d), .tx_k_o (tx_b_k), .channel_ready_o (rdy_b)
    );

    function automatic int bkind(input logic [DW-1:0] d, input logic [KW-1:0] k);
        logic [15:0] l0;
        logic [1:0]  k0;
        l0 = d[15:0];
        k0 = k[1:0];
        if (d != {LANES{l0}} || k != {LANES{k0}}) return K_BAD;
        if (l0 == 16'h0000 && k0 == 2'b00) return K_IDLE;
        if (l0 == 16'h4ABC && k0 == 2'b01) return K_ALIGN;
        if (l0 == 16'h5CBC && k0 == 2'b01) return K_OK;
        if (l0 == 16'h7C7C && k0 == 2'b11) return K_DSK;
        if (l0 == 16'h6EBC && k0 == 2'b01) return K_ACK;
        return K_BAD;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-node protocol monitors, sampled between edges
    logic [DW-1:0] m_txd [2];
    logic [KW-1:0] m_txk [2];
    logic [DW-1:0] m_rxd [2];
    logic [KW-1:0] m_rxk [2];
    logic          m_rst [2];
    logic          m_rdy [2];
    assign m_txd[0] = tx_a_d; assign m_txk[0] = tx_a_k;
    assign m_txd[1] = tx_b_d; assign m_txk[1] = tx_b_k;
    assign m_rxd[0] = rx_a_d; assign m_rxk[0] = rx_a_k;
    assign m_rxd[1] = rx_b_d; assign m_rxk[1] = rx_b_k;
    assign m_rst[0] = rst_a | lost_a; assign m_rst[1] = rst_b | lost_b;
    assign m_rdy[0] = rdy_a; assign m_rdy[1] = rdy_b;

    bit seen_ok [2], seen_dsk [2], seen_ack [2], prev_rdy [2];
    int prev_kind [2];

    always @(negedge clk) begin
        for (int n = 0; n < 2; n++) begin
            int tk, rk;
            tk = bkind(m_txd[n], m_txk[n]);
            rk = bkind(m_rxd[n], m_rxk[n]);
            if (tk == K_BAD) chk(1'b0, "R10 lanes differ on tx", tk, K_IDLE);
            if (tk == K_DSK && prev_kind[n] != K_DSK)
                chk(seen_ok[n], "R5 deskew needs peer confirm", int'(seen_ok[n]), 1);
            if (prev_kind[n] == K_DSK)
                chk(tk == K_IDLE, "R6 deskew lasts one cycle", tk, K_IDLE);
            if (tk == K_ACK && prev_kind[n] != K_ACK)
                chk(seen_dsk[n], "R7 ack needs peer deskew", int'(seen_dsk[n]), 1);
            if (m_rdy[n] && !prev_rdy[n])
                chk(seen_ack[n], "R8 ready needs peer ack", int'(seen_ack[n]), 1);
            if (m_rst[n]) begin
                seen_ok[n] = 0; seen_dsk[n] = 0; seen_ack[n] = 0;
            end else begin
                if (rk == K_OK)  seen_ok[n]  = 1;
                if (rk == K_DSK) seen_dsk[n] = 1;
                if (rk == K_ACK) seen_ack[n] = 1;
            end
            prev_kind[n] = tk;
            prev_rdy[n]  = m_rdy[n];
        end
    end

    // one window on node A with a forced receive pattern
    task automatic win_test(input logic [15:0] lane_d, input logic [1:0] lane_k,
                            input logic [LANES-1:0] lane_mask, input int pulse_at,
                            input int exp_next, input string tag);
        int count;
        logic [DW-1:0] wd;
        logic [KW-1:0] wk;
        for (int l = 0; l < LANES; l++) begin
            wd[l*16 +: 16] = lane_mask[l] ? lane_d : 16'h0000;
            wk[l*2 +: 2]   = lane_mask[l] ? lane_k : 2'b00;
        end
        inj_en = 1'b1;
        inj_d = '0; inj_k = '0;
        rst_a = 1'b1;
        repeat (2) @(negedge clk);
        rst_a = 1'b0;
        @(negedge clk);
        count = 0;
        while (bkind(tx_a_d, tx_a_k) == K_ALIGN && count < WIN + 8) begin
            if (pulse_at < 0 || count == pulse_at) begin
                inj_d = wd; inj_k = wk;
            end else begin
                inj_d = '0; inj_k = '0;
            end
            count++;
            @(negedge clk);
        end
        inj_d = '0; inj_k = '0;
        chk(count == WIN, {"R2 window length ", tag}, count, WIN);
        chk(bkind(tx_a_d, tx_a_k) == exp_next, tag, bkind(tx_a_d, tx_a_k), exp_next);
        if (exp_next == K_IDLE) begin
            @(negedge clk);
            chk(bkind(tx_a_d, tx_a_k) == K_ALIGN, "R3 window reopens", bkind(tx_a_d, tx_a_k), K_ALIGN);
        end
    endtask

    task automatic pair_test(input int lab, input int lba, input int offa, input int offb);
        int waited;
        inj_en = 1'b0;
        rst_a = 1'b1; rst_b = 1'b1;
        lat_ab = lab; lat_ba = lba;
        repeat (MAXLAT + 4) @(negedge clk);
        for (int c = 0; c <= ((offa > offb) ? offa : offb); c++) begin
            if (c == offa) rst_a = 1'b0;
            if (c == offb) rst_b = 1'b0;
            @(negedge clk);
        end
        waited = 0;
        while (!(rdy_a && rdy_b) && waited < 4000) begin
            waited++;
            @(negedge clk);
        end
        chk(rdy_a, "R11 node A ready", int'(rdy_a), 1);
        chk(rdy_b, "R11 node B ready", int'(rdy_b), 1);
        repeat (40) @(negedge clk);
        chk(rdy_a && rdy_b, "R8 ready holds", int'(rdy_a && rdy_b), 1);
        chk(bkind(tx_a_d, tx_a_k) == K_IDLE, "R8 idle while ready", bkind(tx_a_d, tx_a_k), K_IDLE);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_a = 1'b1; rst_b = 1'b1; lost_a = 1'b0; lost_b = 1'b0;
        inj_en = 1'b1; inj_d = '0; inj_k = '0;
        lat_ab = 1; lat_ba = 1;
        repeat (3) @(negedge clk);
        chk(!rdy_a, "R1 ready low in reset", int'(rdy_a), 0);
        chk(bkind(tx_a_d, tx_a_k) == K_IDLE, "R1 idle in reset", bkind(tx_a_d, tx_a_k), K_IDLE);

        // forced windows on node A, peer held in reset
        win_test(16'h0000, 2'b00, 4'hF, -1, K_IDLE, "R3 no peer restarts");
        win_test(16'h4ABC, 2'b01, 4'hF, -1, K_OK,   "R4 align seen");
        win_test(16'h5CBC, 2'b01, 4'hF, -1, K_OK,   "R4 confirm counts");
        win_test(16'h4ABC, 2'b01, 4'hF, 0,  K_OK,   "R4 hit first cycle");
        win_test(16'h4ABC, 2'b01, 4'hF, WIN-1, K_OK, "R4 hit last cycle");
        win_test(16'h4ABC, 2'b01, 4'h7, -1, K_IDLE, "R10 three lanes ignored");
        win_test(16'h4ABC, 2'b00, 4'hF, -1, K_IDLE, "R10 missing K ignored");
        win_test(16'h4ABC, 2'b11, 4'hF, -1, K_IDLE, "R10 extra K ignored");

        // back-to-back pairs
        pair_test(1, 1, 0, 0);
        pair_test(3, 7, 0, 40);
        pair_test(12, 2, 100, 0);
        pair_test(5, 5, 0, 3*WIN + 5);
        pair_test(8, 1, 30, 31);
        pair_test(2, 11, 0, 200);

        // loss of alignment while up
        @(negedge clk);
        lost_a = 1'b1;
        @(negedge clk);
        lost_a = 1'b0;
        chk(!rdy_a, "R9 loss drops ready", int'(rdy_a), 0);
        @(negedge clk);
        chk(bkind(tx_a_d, tx_a_k) == K_ALIGN, "R9 restarts alignment", bkind(tx_a_d, tx_a_k), K_ALIGN);
        chk(rdy_b, "R8 peer ready unaffected", int'(rdy_b), 1);

        // reset while up
        rst_b = 1'b1;
        @(negedge clk);
        chk(!rdy_b, "R9 reset drops ready", int'(rdy_b), 0);
        chk(bkind(tx_b_d, tx_b_k) == K_IDLE, "R1 reset idles tx", bkind(tx_b_d, tx_b_k), K_IDLE);

        // both recover after a mid-link reset
        pair_test(4, 9, 10, 0);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule